// File: doc/BRIEF.md
# Sector Hamming ECC Corrector

This block checks one 512-byte data sector against a 24-bit Hamming-style check code and repairs it when it can. The sector sits in a local byte RAM. A plain write port loads the RAM and a read port returns its contents. After the sector is loaded, the user presents two codes and pulses `start`. The first code is the one read back from the spare area, which holds it inverted. The second is the code calculated over the received data.

The block splits the difference between the two codes into an odd and an even 12-bit syndrome and sorts the outcome into one of four classes. The classes are: clean, a single flipped data bit, a single flipped bit in the check code, or an uncorrectable pattern. For a single data-bit error, the block reads the affected byte, inverts the one bit and writes the byte back. A fixed, short number of cycles after `start`, it pulses `done` and presents the 2-bit result.

Top module: `sec_ecc_corrector`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 2'b00.
- R2: When idle, a byte written with `wr_en` at `wr_addr` appears on `rd_data` on the clock edge after `rd_addr` selects it.
- R3: The block uses `stored_code` only after complementing it. When both syndromes are zero, `result` is 2'b00 (none), the sector is unchanged, and `done` pulses in the first cycle after the edge that takes `start`.
- R4: Each 24-bit code is split into two 12-bit words. The low word is byte 0 (code bits 7:0) with the low nibble of byte 1 as bits 11:8. The high word is the high nibble of byte 1 as bits 3:0 with byte 2 as bits 11:4. The odd syndrome is the XOR of the two low words and the even syndrome is the XOR of the two high words.
- R5: When the odd syndrome equals the 12-bit complement of the even syndrome, `result` is 2'b01 (data corrected). The block inverts the bit at byte offset odd[11:3], bit position odd[2:0], and changes no other bit. `done` pulses in the third cycle after the edge that takes `start`.
- R6: Otherwise, when the OR of the two syndromes has exactly one bit set, `result` is 2'b10 (code-bit error). The sector is unchanged and `done` pulses in the first cycle after start.
- R7: Any other non-zero syndrome gives `result` 2'b11 (uncorrectable). The sector is unchanged and `done` pulses in the first cycle after start.
- R8: `busy` is high from the cycle after an accepted start through the `done` cycle. `done` lasts one cycle. A `start` raised while busy is ignored.
- R9: Writes on the external port while `busy` is high have no effect on the sector.
- R10: `result` keeps its value from one accepted start until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Sector byte write strobe (idle only) |
| wr_addr | input | 9 | Sector byte write address |
| wr_data | input | 8 | Sector byte write data |
| rd_addr | input | 9 | Sector byte read address |
| rd_data | output | 8 | Registered read data |
| start | input | 1 | Begin check and repair |
| stored_code | input | 24 | Check code from the spare area, as stored (inverted) |
| calc_code | input | 24 | Check code calculated over the received sector |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 none, 01 data corrected, 10 code-bit error, 11 uncorrectable |

## Verification
The assertions assume `start` is a clean level sampled at the clock edge. They also assume the codes are stable in the cycle `start` is taken, since they are captured only then. They ignore the external ports while `busy` is high. The stimulus drives every input on the falling edge and holds the codes with `start`. Each operation finishes before the next sector access, except in the deliberate tests of an ignored start and an ignored write during `busy`.

// File: rtl/sec_ecc_pkg.sv
package sec_ecc_pkg;
  localparam int SEC_BYTES = 512;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = $clog2(SEC_BYTES);
  localparam int BIT_W     = $clog2(BYTE_W);
  localparam int HALF_W    = ADDR_W + BIT_W;
  localparam int CODE_W    = 2 * HALF_W;

  typedef enum logic [1:0] {
    RES_NONE = 2'b00,
    RES_DATA = 2'b01,
    RES_CODE = 2'b10,
    RES_FAIL = 2'b11
  } ecc_res_e;

  // low word: byte 0 plus the low nibble of byte 1 on top
  function automatic logic [HALF_W-1:0] code_lo(input logic [CODE_W-1:0] c);
    return c[HALF_W-1:0];
  endfunction

  // high word: the high nibble of byte 1 at the bottom, byte 2 above it
  function automatic logic [HALF_W-1:0] code_hi(input logic [CODE_W-1:0] c);
    return c[CODE_W-1:HALF_W];
  endfunction

  function automatic ecc_res_e classify(input logic [HALF_W-1:0] odd_s,
                                        input logic [HALF_W-1:0] even_s);
    if (odd_s == '0 && even_s == '0)       return RES_NONE;
    else if (odd_s == ~even_s)             return RES_DATA;
    else if ($countones(odd_s | even_s) == 1) return RES_CODE;
    else                                   return RES_FAIL;
  endfunction

  function automatic logic [BYTE_W-1:0] bit_mask(input logic [BIT_W-1:0] pos);
    return BYTE_W'(1) << pos;
  endfunction
endpackage

// File: rtl/sec_ecc_syndrome.sv
module sec_ecc_syndrome
  import sec_ecc_pkg::*;
(
  input  logic [CODE_W-1:0] stored_code,
  input  logic [CODE_W-1:0] calc_code,
  output ecc_res_e          cls,
  output logic [HALF_W-1:0] err_loc
);
  logic [CODE_W-1:0] read_code;
  logic [HALF_W-1:0] odd_syn, even_syn;

  // spare area keeps the code inverted
  assign read_code = ~stored_code;
  assign odd_syn   = code_lo(read_code) ^ code_lo(calc_code);
  assign even_syn  = code_hi(read_code) ^ code_hi(calc_code);
  assign cls       = classify(odd_syn, even_syn);
  assign err_loc   = odd_syn;
endmodule

// File: rtl/sec_ecc_sector_ram.sv
module sec_ecc_sector_ram #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sec_ecc_fix_ctrl.sv
module sec_ecc_fix_ctrl
  import sec_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  ecc_res_e          cls_in,
  input  logic [HALF_W-1:0] loc_in,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic              busy,
  output logic              done,
  output ecc_res_e          result,
  output logic [ADDR_W-1:0] fix_addr,
  output logic              fix_we,
  output logic [BYTE_W-1:0] fix_wdata
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_FIN} st_e;
  st_e               state;
  logic [HALF_W-1:0] loc_q;
  logic              accept;

  assign accept = start && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      result <= RES_NONE;
      loc_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          result <= cls_in;
          loc_q  <= loc_in;
          state  <= (cls_in == RES_DATA) ? ST_READ : ST_FIN;
        end
        ST_READ:  state <= ST_WRITE;
        ST_WRITE: state <= ST_FIN;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign fix_addr  = loc_q[HALF_W-1:BIT_W];
  assign fix_we    = (state == ST_WRITE);
  assign fix_wdata = ram_rdata ^ bit_mask(loc_q[BIT_W-1:0]);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  p_fast_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cls_in != RES_DATA) |=> done);
  p_write_then_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fix_we |=> done);
  p_write_only_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fix_we |-> (result == RES_DATA));
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(result));
endmodule

// File: rtl/sec_ecc_corrector.sv
module sec_ecc_corrector
  import sec_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              start,
  input  logic [CODE_W-1:0] stored_code,
  input  logic [CODE_W-1:0] calc_code,
  output logic              busy,
  output logic              done,
  output logic [1:0]        result
);
  ecc_res_e          cls, res_e;
  logic [HALF_W-1:0] err_loc;
  logic [ADDR_W-1:0] fix_addr, ram_waddr, ram_raddr;
  logic              fix_we, ram_we;
  logic [BYTE_W-1:0] fix_wdata, ram_wdata, ram_rdata;

  sec_ecc_syndrome u_syn (
    .stored_code (stored_code),
    .calc_code   (calc_code),
    .cls         (cls),
    .err_loc     (err_loc)
  );

  sec_ecc_fix_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cls_in    (cls),
    .loc_in    (err_loc),
    .ram_rdata (ram_rdata),
    .busy      (busy),
    .done      (done),
    .result    (res_e),
    .fix_addr  (fix_addr),
    .fix_we    (fix_we),
    .fix_wdata (fix_wdata)
  );

  // the corrector owns the RAM while busy; outside writes are dropped
  assign ram_we    = busy ? fix_we    : wr_en;
  assign ram_waddr = busy ? fix_addr  : wr_addr;
  assign ram_wdata = busy ? fix_wdata : wr_data;
  assign ram_raddr = busy ? fix_addr  : rd_addr;

  sec_ecc_sector_ram #(.DEPTH(SEC_BYTES), .DATA_W(BYTE_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  assign rd_data = ram_rdata;
  assign result  = res_e;

  p_flip_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fix_we |-> ($countones(fix_wdata ^ ram_rdata) == 1));
  p_done_implies_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
endmodule

// File: tb/sec_ecc_corrector_tb.sv
module sec_ecc_corrector_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [8:0]  wr_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [8:0]  rd_addr = 0;
  logic [7:0]  rd_data;
  logic        start = 0;
  logic [23:0] stored_code = 0;
  logic [23:0] calc_code = 0;
  logic        busy, done;
  logic [1:0]  result;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [7:0] model [512];

  sec_ecc_corrector u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .start(start), .stored_code(stored_code), .calc_code(calc_code),
    .busy(busy), .done(done), .result(result)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected < 190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bench's own classification, built byte by byte from the packing rule
  function automatic logic [1:0] ref_class(input logic [23:0] rd, input logic [23:0] cc);
    logic [11:0] rl, rh, cl, ch, od, ev;
    rl = {rd[11:8], rd[7:0]};  rh = {rd[23:16], rd[15:12]};
    cl = {cc[11:8], cc[7:0]};  ch = {cc[23:16], cc[15:12]};
    od = rl ^ cl; ev = rh ^ ch;
    if ((od | ev) == 12'h000) return 2'b00;
    if ((od ^ ev) == 12'hFFF) return 2'b01;
    if ($countones(od | ev) == 1) return 2'b10;
    return 2'b11;
  endfunction

  task automatic wr_byte(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a[8:0]; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_check(input int a, input string req);
    @(negedge clk); rd_addr = a[8:0];
    @(negedge clk);
    check(req, {24'h0, rd_data}, {24'h0, model[a]});
  endtask

  task automatic run_case(input logic [23:0] rdcode, input logic [23:0] cc,
                          input string req, input int flip_at);
    int lat; logic [1:0] er; int ebyte;
    er = ref_class(rdcode, cc);
    @(negedge clk);
    start = 1; stored_code = ~rdcode; calc_code = cc;
    @(negedge clk);
    start = 0;
    check({req, " busy"}, {31'h0, busy}, 32'h1);
    lat = 0;
    for (int k = 1; k <= 5; k++) begin
      if (k > 1) @(negedge clk);
      if (done && lat == 0) lat = k;
    end
    check({req, " result"}, {30'h0, result}, {30'h0, er});
    check({req, " latency"}, lat, (er == 2'b01) ? 3 : 1);
    check("R8 idle after", {31'h0, busy}, 32'h0);
    if (er == 2'b01) begin
      ebyte = flip_at >> 3;
      model[ebyte] = model[ebyte] ^ (8'h1 << (flip_at & 7));
      rd_check(ebyte, "R5 flipped byte");
      rd_check((ebyte + 1) % 512, "R5 neighbour");
    end
  endtask

  task automatic sweep_sector(input string req);
    for (int a = 0; a < 512; a++) rd_check(a, req);
  endtask

  initial begin
    logic [23:0] cc;
    logic [11:0] loc;
    repeat (3) @(negedge clk);
    check("R1 busy", {31'h0, busy}, 0);
    check("R1 done", {31'h0, done}, 0);
    check("R1 result", {30'h0, result}, 0);
    rst_n = 1;

    for (int a = 0; a < 512; a++) begin
      model[a] = 8'((a * 37 + 11) ^ (a >> 3));
      wr_byte(a, model[a]);
    end
    sweep_sector("R2 load");

    // R3: clean codes
    for (int t = 0; t < 8; t++) begin
      cc = 24'($urandom);
      run_case(cc, cc, "R3 clean", 0);
    end
    sweep_sector("R3 unchanged");

    // R4/R5: hand-built byte-level code, byte 0x15A bit 5
    cc = 24'h3C81E7;
    run_case(cc ^ 24'h52AAD5, cc, "R4 packing", 12'hAD5);

    // R5: every data bit position
    for (int p = 0; p < 4096; p++) begin
      loc = 12'(p);
      cc = 24'($urandom);
      run_case(cc ^ {~loc, loc}, cc, "R5 sweep", p);
    end

    // R6: every code bit
    for (int k = 0; k < 24; k++) begin
      cc = 24'($urandom);
      run_case(cc ^ (24'h1 << k), cc, "R6 code bit", 0);
    end
    // R6 corner: same position in both halves also leaves one OR bit
    run_case(24'h001001 ^ 24'hABCDEF, 24'hABCDEF, "R6 paired", 0);

    // R7: random double errors
    for (int t = 0; t < 200; t++) begin
      int i, j;
      i = int'($urandom % 24);
      j = int'((i + 1 + ($urandom % 23)) % 24);
      cc = 24'($urandom);
      run_case(cc ^ (24'h1 << i) ^ (24'h1 << j), cc, "R7 double", 0);
    end
    run_case(24'h000003, 24'h0, "R7 two low", 0);
    sweep_sector("R7 unchanged");

    // R8 start while busy ignored; R9 write while busy ignored
    loc = 12'h023;
    @(negedge clk);
    start = 1; calc_code = 24'h0; stored_code = ~{~loc, loc};
    @(negedge clk);
    start = 1; stored_code = ~24'h000003;
    wr_en = 1; wr_addr = 9'd100; wr_data = ~model[100];
    @(negedge clk);
    start = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    check("R8 second start ignored", {30'h0, result}, 32'h1);
    model[4] = model[4] ^ 8'h08;
    rd_check(4, "R8 single flip");
    rd_check(100, "R9 write during busy");

    // R10 result holds while idle
    repeat (6) @(negedge clk);
    check("R10 hold", {30'h0, result}, 32'h1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule